// File: doc/BRIEF.md
# Two-Tone Quadrature Energy Bit Detector

This block turns a stream of signed samples carrying a two-frequency keyed signal into data bits. Each accepted sample is multiplied by a cosine and a sine reference for the lower ("space") tone and for the upper ("mark") tone. The references come from two phase accumulators stepped by programmable increments. A parabolic sine approximation converts the phase to a reference value. The four products are smoothed by first-order low-pass filters that use only shift and add. For each tone, the pair of filtered values is rectified into a magnitude, |I| + |Q|, and that magnitude is summed once per cycle while a result from the pipeline is pending.

A chip boundary is marked by a one-cycle tick from outside, and carrier and chip alignment are generated elsewhere. At the tick the block closes both sums and compares them. The next cycle it presents the bit, a one-cycle valid pulse and both energy values. The sums then restart for the following chip.

Top module: `dual_tone_demod`

## Requirements
- R1: After a synchronous active-high reset, bitOut, bitValid, spaceEnergy and markEnergy are all 0, and the filters and phase accumulators are zero.
- R2: A sample with sampleValid low is ignored. It advances neither phase accumulator, it does not enter the filters and it adds no energy. A chip whose valid samples are interleaved with invalid garbage therefore reports exactly the energies of the same valid samples delivered back to back.
- R3: A chip dominated by a tone at the mark increment yields bitOut = 1 with markEnergy > spaceEnergy.
- R4: A chip dominated by a tone at the space increment yields bitOut = 0 with spaceEnergy > markEnergy.
- R5: bitOut is 1 only when markEnergy is strictly greater than spaceEnergy. Equal energies, including the all-zero case that follows zero-valued samples from reset, give bitOut = 0.
- R6: bitValid is high in the cycle after each chipTick and in no other cycle. bitOut and both energies change only in the cycle after a chipTick and hold their values otherwise.
- R7: At a chipTick both sums restart from zero. A magnitude that reaches the sum in the tick cycle is counted in the chip that is closing, so every contribution lands in exactly one chip. A second tick with no new samples reports zero energies.
- R8: Successive ticks, and reset and the first tick, are at most 2^CHIP_W cycles apart. Within that limit the energy sums never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | SAMPLE_W | Signed input sample |
| sampleValid | input | 1 | sampleIn is accepted this cycle |
| spaceIncr | input | PHASE_W | Phase step per sample of the space reference |
| markIncr | input | PHASE_W | Phase step per sample of the mark reference |
| chipTick | input | 1 | Closes the current chip this cycle |
| bitOut | output | 1 | Decided bit of the last closed chip |
| bitValid | output | 1 | One-cycle pulse when a new decision is presented |
| spaceEnergy | output | ACC_W | Summed space magnitude of the last closed chip |
| markEnergy | output | ACC_W | Summed mark magnitude of the last closed chip |

## Verification
The chip close and the summing of a new magnitude can happen in the same cycle. This case is forced by raising chipTick together with a valid sample while the three-stage pipeline is full, so a magnitude reaches the sums in the tick cycle. The bench judges the result by splitting one recorded tone burst into two chips at that point. It then compares the sum of the two chips' energies, tone by tone, with a run of the same burst from reset that is closed by a single tick after the pipeline has drained. A second pairing compares gapped input with contiguous input of the same samples. Both pairings require exact equality.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  localparam int NUM_TONES = 2;
  localparam int TONE_SPACE = 0;
  localparam int TONE_MARK = 1;

  typedef struct packed {
    logic mixEn;
    logic filtEn;
    logic accEn;
    logic chipClose;
  } strobe_t;
endpackage

// File: rtl/dtd_ref_gen.sv
module dtd_ref_gen #(
  parameter int PHASE_W = 16,
  parameter int LUT_W = 8,
  parameter int REF_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic [PHASE_W-1:0] incr,
  output logic signed [REF_W-1:0] cosRef,
  output logic signed [REF_W-1:0] sinRef
);
  localparam int T_W = LUT_W - 1;
  localparam int SQ_W = 2 * T_W;
  localparam int SHIFT = SQ_W - 2 - (REF_W - 1);
  localparam logic [SQ_W:0] FULL = (SQ_W+1)'(1) << T_W;
  localparam logic [SQ_W:0] MAXMAG = (SQ_W+1)'((1 << (REF_W - 1)) - 1);
  localparam logic [LUT_W-1:0] QUARTER = LUT_W'(1) << (LUT_W - 2);

  logic [PHASE_W-1:0] phase;
  logic [LUT_W-1:0] sinIdx;
  logic [LUT_W-1:0] cosIdx;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (advance) phase <= phase + incr;
  end

  // Half-wave parabola 4t(1-t), mirrored for the lower half-cycle.
  function automatic logic signed [REF_W-1:0] wave(input logic [LUT_W-1:0] idx);
    logic [SQ_W:0] tw;
    logic [SQ_W:0] rw;
    logic [SQ_W:0] pr;
    logic [SQ_W:0] mw;
    tw = (SQ_W+1)'(idx[T_W-1:0]);
    rw = FULL - tw;
    pr = tw * rw;
    mw = pr >> SHIFT;
    if (mw > MAXMAG) mw = MAXMAG;
    wave = idx[LUT_W-1] ? -$signed(mw[REF_W-1:0]) : $signed(mw[REF_W-1:0]);
  endfunction

  assign sinIdx = phase[PHASE_W-1 -: LUT_W];
  assign cosIdx = sinIdx + QUARTER;
  assign sinRef = wave(sinIdx);
  assign cosRef = wave(cosIdx);
endmodule

// File: rtl/dtd_ctrl.sv
module dtd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sampleValid,
  input  logic chipTick,
  output dtd_pkg::strobe_t strobe,
  output logic bitValid
);
  logic mixDone;
  logic filtDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      mixDone <= 1'b0;
      filtDone <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      mixDone <= sampleValid;
      filtDone <= mixDone;
      bitValid <= chipTick;
    end
  end

  always_comb begin
    strobe.mixEn = sampleValid;
    strobe.filtEn = mixDone;
    strobe.accEn = filtDone;
    strobe.chipClose = chipTick;
  end
endmodule

// File: rtl/dtd_datapath.sv
module dtd_datapath #(
  parameter int SAMPLE_W = 12,
  parameter int PHASE_W = 16,
  parameter int LUT_W = 8,
  parameter int REF_W = 10,
  parameter int FILT_K = 4,
  parameter int CHIP_W = 12,
  localparam int PROD_W = SAMPLE_W + REF_W,
  localparam int FILT_W = PROD_W + 1,
  localparam int MAG_W = FILT_W + 1,
  localparam int ACC_W = MAG_W + CHIP_W
) (
  input  logic clk,
  input  logic rst,
  input  dtd_pkg::strobe_t strobe,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [PHASE_W-1:0] spaceIncr,
  input  logic [PHASE_W-1:0] markIncr,
  output logic bitOut,
  output logic [ACC_W-1:0] spaceEnergy,
  output logic [ACC_W-1:0] markEnergy
);
  import dtd_pkg::*;

  logic [PHASE_W-1:0] incrSel [NUM_TONES];
  assign incrSel[TONE_SPACE] = spaceIncr;
  assign incrSel[TONE_MARK] = markIncr;

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    logic signed [REF_W-1:0] cosR;
    logic signed [REF_W-1:0] sinR;
    logic signed [PROD_W-1:0] prodI;
    logic signed [PROD_W-1:0] prodQ;
    logic signed [FILT_W-1:0] filtI;
    logic signed [FILT_W-1:0] filtQ;
    logic signed [FILT_W-1:0] stepI;
    logic signed [FILT_W-1:0] stepQ;
    logic [FILT_W-1:0] absI;
    logic [FILT_W-1:0] absQ;
    logic [MAG_W-1:0] mag;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sumNext;
    logic [ACC_W-1:0] energy;

    dtd_ref_gen #(.PHASE_W(PHASE_W), .LUT_W(LUT_W), .REF_W(REF_W)) u_ref (
      .clk(clk),
      .rst(rst),
      .advance(strobe.mixEn),
      .incr(incrSel[t]),
      .cosRef(cosR),
      .sinRef(sinR)
    );

    always_comb begin
      stepI = (FILT_W'(prodI) - filtI) >>> FILT_K;
      stepQ = (FILT_W'(prodQ) - filtQ) >>> FILT_K;
      absI = filtI[FILT_W-1] ? FILT_W'(-filtI) : FILT_W'(filtI);
      absQ = filtQ[FILT_W-1] ? FILT_W'(-filtQ) : FILT_W'(filtQ);
      mag = MAG_W'(absI) + MAG_W'(absQ);
      sumNext = acc + (strobe.accEn ? ACC_W'(mag) : '0);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prodI <= '0;
        prodQ <= '0;
        filtI <= '0;
        filtQ <= '0;
        acc <= '0;
        energy <= '0;
      end else begin
        if (strobe.mixEn) begin
          prodI <= PROD_W'(sampleIn) * PROD_W'(cosR);
          prodQ <= PROD_W'(sampleIn) * PROD_W'(sinR);
        end
        if (strobe.filtEn) begin
          filtI <= filtI + stepI;
          filtQ <= filtQ + stepQ;
        end
        if (strobe.chipClose) begin
          energy <= sumNext;
          acc <= '0;
        end else begin
          acc <= sumNext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bitOut <= 1'b0;
    else if (strobe.chipClose)
      bitOut <= g_tone[TONE_MARK].sumNext > g_tone[TONE_SPACE].sumNext;
  end

  assign spaceEnergy = g_tone[TONE_SPACE].energy;
  assign markEnergy = g_tone[TONE_MARK].energy;
endmodule

// File: rtl/dual_tone_demod.sv
module dual_tone_demod #(
  parameter int SAMPLE_W = 12,
  parameter int PHASE_W = 16,
  parameter int LUT_W = 8,
  parameter int REF_W = 10,
  parameter int FILT_K = 4,
  parameter int CHIP_W = 12,
  localparam int ACC_W = SAMPLE_W + REF_W + 2 + CHIP_W
) (
  input  logic clk,
  input  logic rst,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic sampleValid,
  input  logic [PHASE_W-1:0] spaceIncr,
  input  logic [PHASE_W-1:0] markIncr,
  input  logic chipTick,
  output logic bitOut,
  output logic bitValid,
  output logic [ACC_W-1:0] spaceEnergy,
  output logic [ACC_W-1:0] markEnergy
);
  dtd_pkg::strobe_t strobe;

  dtd_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .sampleValid(sampleValid),
    .chipTick(chipTick),
    .strobe(strobe),
    .bitValid(bitValid)
  );

  dtd_datapath #(
    .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .LUT_W(LUT_W),
    .REF_W(REF_W), .FILT_K(FILT_K), .CHIP_W(CHIP_W)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .sampleIn(sampleIn),
    .spaceIncr(spaceIncr),
    .markIncr(markIncr),
    .bitOut(bitOut),
    .spaceEnergy(spaceEnergy),
    .markEnergy(markEnergy)
  );
endmodule

// File: rtl/dtd_checker.sv
module dtd_checker #(
  parameter int ACC_W = 36,
  parameter int CHIP_W = 12
) (
  input logic clk,
  input logic rst,
  input logic chipTick,
  input logic bitOut,
  input logic bitValid,
  input logic [ACC_W-1:0] spaceEnergy,
  input logic [ACC_W-1:0] markEnergy
);
  localparam logic [CHIP_W:0] MAXC = (CHIP_W+1)'(1) << CHIP_W;
  logic [CHIP_W:0] sinceTick;

  always_ff @(posedge clk) begin
    if (rst || chipTick) sinceTick <= '0;
    else if (sinceTick != MAXC) sinceTick <= sinceTick + 1'b1;
  end

  p_valid_follows_tick_r6: assert property (@(posedge clk) disable iff (rst)
    chipTick |=> bitValid);

  p_valid_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    bitValid |-> $past(chipTick));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !chipTick |=> ($stable(bitOut) && $stable(markEnergy) && $stable(spaceEnergy)));

  p_decision_rule_r5: assert property (@(posedge clk) disable iff (rst)
    bitValid |-> (bitOut == (markEnergy > spaceEnergy)));

  p_chip_len_r8: assert property (@(posedge clk) disable iff (rst)
    sinceTick < MAXC);
endmodule

bind dual_tone_demod dtd_checker #(.ACC_W(ACC_W), .CHIP_W(CHIP_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .chipTick(chipTick),
  .bitOut(bitOut),
  .bitValid(bitValid),
  .spaceEnergy(spaceEnergy),
  .markEnergy(markEnergy)
);

// File: tb/dual_tone_demod_tb_top.sv
module dual_tone_demod_tb_top;
  localparam int ACC_W = 36;
  localparam logic [15:0] SPACE_INC = 16'h0800;
  localparam logic [15:0] MARK_INC = 16'h1000;

  // Vector table: tone kind (0 space, 1 mark), amplitude, chip length, expected bit
  localparam int VEC_N = 6;
  localparam int vecKind [VEC_N] = '{1, 0, 1, 1, 0, 0};
  localparam int vecAmp  [VEC_N] = '{1500, 1500, 300, 2000, 600, 2000};
  localparam int vecLen  [VEC_N] = '{256, 256, 200, 300, 256, 128};
  localparam int vecBit  [VEC_N] = '{1, 0, 1, 1, 0, 0};

  logic clk = 1'b0;
  logic rst;
  logic signed [11:0] sampleIn;
  logic sampleValid;
  logic [15:0] spaceIncr;
  logic [15:0] markIncr;
  logic chipTick;
  logic bitOut;
  logic bitValid;
  logic [ACC_W-1:0] spaceEnergy;
  logic [ACC_W-1:0] markEnergy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_tone_demod dut_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .spaceIncr(spaceIncr), .markIncr(markIncr), .chipTick(chipTick),
    .bitOut(bitOut), .bitValid(bitValid),
    .spaceEnergy(spaceEnergy), .markEnergy(markEnergy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; results of the next rising edge are read at the following falling edge.
  task automatic step(input logic signed [11:0] s, input logic v, input logic t);
    sampleIn = s;
    sampleValid = v;
    chipTick = t;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    sampleIn = '0;
    sampleValid = 1'b0;
    chipTick = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic signed [11:0] toneAt(input int kind, input int n, input int amp);
    real f;
    real v;
    f = (kind == 1) ? real'(MARK_INC) / 65536.0 : real'(SPACE_INC) / 65536.0;
    v = real'(amp) * $sin(6.283185307 * f * real'(n) + 0.4);
    return 12'($rtoi(v));
  endfunction

  // Runs a mark burst from the current state; gaps inserts invalid garbage, splitAt ticks mid-burst.
  task automatic burst(input int count, input bit gaps, input int splitAt,
                       output longint eMark, output longint eSpace);
    eMark = 0;
    eSpace = 0;
    for (int n = 0; n < count; n++) begin
      if (gaps && (n % 3 == 1)) step((n % 2 == 1) ? 12'sd2047 : -12'sd1200, 1'b0, 1'b0);
      step(toneAt(1, n, 1000), 1'b1, n == splitAt);
      if (n == splitAt) begin
        chk(bitValid === 1'b1, "R7 coincident tick valid", longint'(bitValid), 1);
        eMark += longint'(markEnergy);
        eSpace += longint'(spaceEnergy);
      end
    end
    repeat (3) step('0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b1);
    eMark += longint'(markEnergy);
    eSpace += longint'(spaceEnergy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint mA, sA, mB, sB, mC, sC;
    logic prevBit;
    spaceIncr = SPACE_INC;
    markIncr = MARK_INC;
    doReset();

    // R1: reset state
    chk(bitOut === 1'b0, "R1 bitOut", longint'(bitOut), 0);
    chk(bitValid === 1'b0, "R1 bitValid", longint'(bitValid), 0);
    chk(markEnergy === '0, "R1 markEnergy", longint'(markEnergy), 0);
    chk(spaceEnergy === '0, "R1 spaceEnergy", longint'(spaceEnergy), 0);

    // Table walk: R3 (mark) and R4 (space) decisions, R6 pulse and hold
    for (int v = 0; v < VEC_N; v++) begin
      for (int n = 0; n < vecLen[v] - 1; n++) begin
        step(toneAt(vecKind[v], n, vecAmp[v]), 1'b1, 1'b0);
        if (v > 0 && n == 0) begin
          chk(bitValid === 1'b0, "R6 pulse one cycle", longint'(bitValid), 0);
          chk(bitOut === prevBit, "R6 bit held", longint'(bitOut), longint'(prevBit));
        end
      end
      step(toneAt(vecKind[v], vecLen[v] - 1, vecAmp[v]), 1'b1, 1'b1);
      chk(bitValid === 1'b1, "R6 valid after tick", longint'(bitValid), 1);
      if (vecBit[v] == 1) begin
        chk(bitOut === 1'b1, "R3 mark bit", longint'(bitOut), 1);
        chk(markEnergy > spaceEnergy, "R3 mark energy larger",
            longint'(markEnergy), longint'(spaceEnergy));
      end else begin
        chk(bitOut === 1'b0, "R4 space bit", longint'(bitOut), 0);
        chk(spaceEnergy > markEnergy, "R4 space energy larger",
            longint'(spaceEnergy), longint'(markEnergy));
      end
      prevBit = bitOut;
    end

    // R5: zero samples from reset give equal zero energies and bit 0
    doReset();
    for (int n = 0; n < 50; n++) step('0, 1'b1, 1'b0);
    step('0, 1'b1, 1'b1);
    chk(bitValid === 1'b1, "R5 valid", longint'(bitValid), 1);
    chk(bitOut === 1'b0, "R5 tie gives 0", longint'(bitOut), 0);
    chk(markEnergy === '0 && spaceEnergy === '0, "R5 zero energy",
        longint'(markEnergy) + longint'(spaceEnergy), 0);

    // R2: invalid garbage between zero samples is ignored
    doReset();
    for (int n = 0; n < 40; n++) begin
      step('0, 1'b1, 1'b0);
      step((n % 2 == 1) ? 12'sd2047 : -12'sd1777, 1'b0, 1'b0);
    end
    repeat (3) step('0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b1);
    chk(markEnergy === '0 && spaceEnergy === '0, "R2 garbage ignored",
        longint'(markEnergy) + longint'(spaceEnergy), 0);

    // Reference run A: contiguous burst, one tick after drain
    doReset();
    burst(160, 1'b0, -1, mA, sA);
    chk(mA > sA, "R3 reference burst", mA, sA);
    // R7: immediate second tick with nothing pending reports zero
    step('0, 1'b0, 1'b1);
    chk(bitValid === 1'b1, "R6 back-to-back valid", longint'(bitValid), 1);
    chk(markEnergy === '0 && spaceEnergy === '0, "R7 cleared after tick",
        longint'(markEnergy) + longint'(spaceEnergy), 0);
    chk(bitOut === 1'b0, "R5 empty chip bit", longint'(bitOut), 0);

    // Run B: same samples with invalid gaps (R2)
    doReset();
    burst(160, 1'b1, -1, mB, sB);
    chk(mB == mA, "R2 gapped mark energy", mB, mA);
    chk(sB == sA, "R2 gapped space energy", sB, sA);

    // Run C: tick coinciding with a valid sample and a pending sum (R7)
    doReset();
    burst(160, 1'b0, 80, mC, sC);
    chk(mC == mA, "R7 split mark energy conserved", mC, mA);
    chk(sC == sA, "R7 split space energy conserved", sC, sA);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule